// File: doc/BRIEF.md
# Interrupt Redirection Table Register File

This block holds the configuration state of an interrupt router and gives software access to it through two registers. An 8-bit index register names one 32-bit internal register. A 32-bit window then reads the named register, or writes it. The internal space holds an identification word, a read-only version word, a boot configuration word and a redirection table. The table has a parameterised number of entries, and each entry is stored as a low dword and a high dword.

Each entry carries a remote-IRR status bit. The delivery logic sets this bit with a per-entry pulse when it sends a level-triggered interrupt. A separate write-only end-of-interrupt port takes an 8-bit vector. In one cycle that vector is compared against the vector field of every entry, and every entry that matches has its remote-IRR bit cleared. The current remote-IRR bits are also driven out as a status vector so that the delivery logic can hold back repeat deliveries.

Top module: `irq_route_regfile`

## Requirements
- R1: After reset the identification word reads 00000000h, the boot configuration word reads 00000001h, every low dword reads 00010000h (the mask at bit 16 is set), every high dword reads 00000000h, and all remote-IRR bits are 0.
- R2: A write on the index port loads the index register at the clock edge. From then on the window read data shows the register that the new index selects.
- R3: Index 00h selects the identification word, 01h the version word and 03h the boot configuration word. Entry n has its low dword at TBL_BASE+2n and its high dword at TBL_BASE+2n+1.
- R4: Window writes change only these bits: identification bits 27:24, boot configuration bit 0, low dword bits 16:15 and 13:0, and high dword bits 31:24. All other bits of those words keep their value.
- R5: The version word is {8'h00, N_ENTRIES-1, 8'h80, 8'h20} (00178020h with the defaults) and cannot be written. Index 02h, indices 04h up to TBL_BASE-1, and every index at or above TBL_BASE+2·N_ENTRIES read as zero, and writes to them have no effect.
- R6: Bit 14 of each low dword shows that entry's remote-IRR bit and is read-only through the window. The bit changes only on a set pulse or on an end-of-interrupt write.
- R7: A pulse on rirr_set[n] sets the remote-IRR bit of entry n on the next edge.
- R8: An end-of-interrupt write clears the remote-IRR bit of every entry whose vector field (low dword bits 7:0) equals the written vector, including several entries that share that vector. Entries that do not match are unchanged.
- R9: If a set pulse and a matching end-of-interrupt write reach an entry in the same cycle, the entry's remote-IRR bit ends up set.
- R10: A window write in the same cycle as an index write goes to the index held before that edge. An end-of-interrupt write in the same cycle as a window write to a vector field compares against the vector held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_we | input | 1 | Index register write strobe |
| idx_wdata | input | 8 | New index value |
| win_we | input | 1 | Window write strobe |
| win_wdata | input | 32 | Window write data |
| win_rdata | output | 32 | Contents of the register selected by the index |
| eoi_we | input | 1 | End-of-interrupt write strobe |
| eoi_vec | input | 8 | Vector being retired |
| rirr_set | input | N_ENTRIES | Per-entry remote-IRR set pulses |
| rirr_status | output | N_ENTRIES | Current remote-IRR bits of all entries |

## Verification
The bench builds the block with its defaults, N_ENTRIES = 24 and TBL_BASE = 10h. With these values the whole 256-index space is swept, the version word carries 17h in its entry-count field, and the last high dword at 3Fh sits right next to the first reserved index at 40h, so both sides of that boundary are checked. Random vectors are drawn from a set of four values, which makes shared vectors and multi-entry clears frequent. Directed cases cover set/clear collisions and same-cycle index, window and end-of-interrupt writes.

// File: rtl/irq_rf_pkg.sv
package irq_rf_pkg;

    localparam logic [31:0] ID_RESET   = 32'h0000_0000;
    localparam logic [31:0] BCFG_RESET = 32'h0000_0001;
    localparam logic [31:0] LO_RESET   = 32'h0001_0000;
    localparam logic [31:0] HI_RESET   = 32'h0000_0000;

    localparam logic [31:0] ID_WMASK   = 32'h0F00_0000;
    localparam logic [31:0] BCFG_WMASK = 32'h0000_0001;
    localparam logic [31:0] LO_WMASK   = 32'h0001_BFFF;
    localparam logic [31:0] HI_WMASK   = 32'hFF00_0000;

    localparam int RIRR_BIT = 14;

    typedef enum logic [2:0] {
        SEL_ID,
        SEL_VER,
        SEL_BCFG,
        SEL_LO,
        SEL_HI,
        SEL_NONE
    } sel_e;

    function automatic logic [31:0] merge_bits(input logic [31:0] old_v,
                                               input logic [31:0] new_v,
                                               input logic [31:0] mask);
        return (old_v & ~mask) | (new_v & mask);
    endfunction

    function automatic logic [31:0] version_word(input int n_entries);
        return {8'h00, 8'(n_entries - 1), 8'h80, 8'h20};
    endfunction

endpackage

// File: rtl/irq_rf_decode.sv
module irq_rf_decode
    import irq_rf_pkg::*;
#(
    parameter int N_ENTRIES = 24,
    parameter int TBL_BASE  = 16,
    localparam int EW       = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic [7:0]    idx,
    output sel_e          sel,
    output logic [EW-1:0] ent
);

    localparam int TBL_END = TBL_BASE + 2 * N_ENTRIES;

    int off;

    always_comb begin
        sel = SEL_NONE;
        ent = '0;
        off = int'(idx) - TBL_BASE;
        if (idx == 8'h00) begin
            sel = SEL_ID;
        end else if (idx == 8'h01) begin
            sel = SEL_VER;
        end else if (idx == 8'h03) begin
            sel = SEL_BCFG;
        end else if (int'(idx) >= TBL_BASE && int'(idx) < TBL_END) begin
            ent = EW'(off >> 1);
            sel = off[0] ? SEL_HI : SEL_LO;
        end
    end

endmodule

// File: rtl/irq_rf_entry.sv
module irq_rf_entry
    import irq_rf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lo_we,
    input  logic        hi_we,
    input  logic [31:0] wdata,
    input  logic        set_pulse,
    input  logic        eoi_en,
    input  logic [7:0]  eoi_vec,
    output logic [31:0] lo_rd,
    output logic [31:0] hi_rd,
    output logic        rirr
);

    logic [31:0] lo_q;
    logic [31:0] hi_q;
    logic        rirr_q;
    logic        eoi_match;

    assign eoi_match = eoi_en && (lo_q[7:0] == eoi_vec);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q   <= LO_RESET;
            hi_q   <= HI_RESET;
            rirr_q <= 1'b0;
        end else begin
            if (lo_we) lo_q <= merge_bits(lo_q, wdata, LO_WMASK);
            if (hi_we) hi_q <= merge_bits(hi_q, wdata, HI_WMASK);
            if (set_pulse)      rirr_q <= 1'b1;
            else if (eoi_match) rirr_q <= 1'b0;
        end
    end

    // bit 14 of lo_q is never written (mask excludes it), so OR-in is exact
    assign lo_rd = lo_q | (32'(rirr_q) << RIRR_BIT);
    assign hi_rd = hi_q;
    assign rirr  = rirr_q;

endmodule

// File: rtl/irq_route_regfile.sv
module irq_route_regfile
    import irq_rf_pkg::*;
#(
    parameter int N_ENTRIES = 24,
    parameter int TBL_BASE  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 idx_we,
    input  logic [7:0]           idx_wdata,
    input  logic                 win_we,
    input  logic [31:0]          win_wdata,
    output logic [31:0]          win_rdata,
    input  logic                 eoi_we,
    input  logic [7:0]           eoi_vec,
    input  logic [N_ENTRIES-1:0] rirr_set,
    output logic [N_ENTRIES-1:0] rirr_status
);

    localparam int EW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;
    localparam logic [31:0] VER_WORD = version_word(N_ENTRIES);

    logic [7:0]    idx_q;
    logic [31:0]   id_q;
    logic [31:0]   bcfg_q;
    sel_e          sel;
    logic [EW-1:0] ent;
    logic [31:0]   lo_all [N_ENTRIES];
    logic [31:0]   hi_all [N_ENTRIES];

    irq_rf_decode #(
        .N_ENTRIES (N_ENTRIES),
        .TBL_BASE  (TBL_BASE)
    ) u_decode (
        .idx (idx_q),
        .sel (sel),
        .ent (ent)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= 8'h00;
            id_q   <= ID_RESET;
            bcfg_q <= BCFG_RESET;
        end else begin
            if (idx_we) idx_q <= idx_wdata;
            if (win_we && sel == SEL_ID)   id_q   <= merge_bits(id_q, win_wdata, ID_WMASK);
            if (win_we && sel == SEL_BCFG) bcfg_q <= merge_bits(bcfg_q, win_wdata, BCFG_WMASK);
        end
    end

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
        logic lo_we_i;
        logic hi_we_i;

        assign lo_we_i = win_we && (sel == SEL_LO) && (ent == EW'(i));
        assign hi_we_i = win_we && (sel == SEL_HI) && (ent == EW'(i));

        irq_rf_entry u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .lo_we     (lo_we_i),
            .hi_we     (hi_we_i),
            .wdata     (win_wdata),
            .set_pulse (rirr_set[i]),
            .eoi_en    (eoi_we),
            .eoi_vec   (eoi_vec),
            .lo_rd     (lo_all[i]),
            .hi_rd     (hi_all[i]),
            .rirr      (rirr_status[i])
        );
    end

    always_comb begin
        unique case (sel)
            SEL_ID:   win_rdata = id_q;
            SEL_VER:  win_rdata = VER_WORD;
            SEL_BCFG: win_rdata = bcfg_q;
            SEL_LO:   win_rdata = lo_all[ent];
            SEL_HI:   win_rdata = hi_all[ent];
            default:  win_rdata = 32'h0;
        endcase
    end

endmodule

// File: rtl/irq_rf_checker.sv
module irq_rf_checker
    import irq_rf_pkg::*;
#(
    parameter int N_ENTRIES = 24,
    parameter int TBL_BASE  = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 idx_we,
    input logic [7:0]           idx_wdata,
    input logic [7:0]           idx_q,
    input logic [31:0]          win_rdata,
    input logic                 eoi_we,
    input logic [7:0]           eoi_vec,
    input logic [N_ENTRIES-1:0] rirr_set,
    input logic [N_ENTRIES-1:0] rirr_status,
    input logic [31:0]          lo_all [N_ENTRIES]
);

    localparam int TBL_END = TBL_BASE + 2 * N_ENTRIES;

    a_r2_index_loads: assert property (@(posedge clk) disable iff (!rst_n)
        idx_we |=> idx_q == $past(idx_wdata));

    a_r5_version_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q == 8'h01) |-> win_rdata == version_word(N_ENTRIES));

    a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(idx_q) >= TBL_END) |-> win_rdata == 32'h0);

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_chk
        a_r7_set_marks: assert property (@(posedge clk) disable iff (!rst_n)
            rirr_set[i] |=> rirr_status[i]);

        // R8 and R9: a match without a set clears
        a_r8_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (eoi_we && lo_all[i][7:0] == eoi_vec && !rirr_set[i]) |=> !rirr_status[i]);

        a_r6_rirr_steady: assert property (@(posedge clk) disable iff (!rst_n)
            (!rirr_set[i] && !(eoi_we && lo_all[i][7:0] == eoi_vec))
                |=> $stable(rirr_status[i]));
    end

endmodule

bind irq_route_regfile irq_rf_checker #(
    .N_ENTRIES (N_ENTRIES),
    .TBL_BASE  (TBL_BASE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .idx_we      (idx_we),
    .idx_wdata   (idx_wdata),
    .idx_q       (idx_q),
    .win_rdata   (win_rdata),
    .eoi_we      (eoi_we),
    .eoi_vec     (eoi_vec),
    .rirr_set    (rirr_set),
    .rirr_status (rirr_status),
    .lo_all      (lo_all)
);

// File: tb/irq_route_regfile_test.sv
module irq_route_regfile_test;

    localparam int N    = 24;
    localparam int BASE = 16;
    localparam int TEND = BASE + 2 * N;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         idx_we = 1'b0;
    logic [7:0]   idx_wdata = '0;
    logic         win_we = 1'b0;
    logic [31:0]  win_wdata = '0;
    logic [31:0]  win_rdata;
    logic         eoi_we = 1'b0;
    logic [7:0]   eoi_vec = '0;
    logic [N-1:0] rirr_set = '0;
    logic [N-1:0] rirr_status;

    always #2 clk = ~clk;

    irq_route_regfile #(.N_ENTRIES(N), .TBL_BASE(BASE)) uut (
        .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .idx_wdata(idx_wdata),
        .win_we(win_we), .win_wdata(win_wdata), .win_rdata(win_rdata),
        .eoi_we(eoi_we), .eoi_vec(eoi_vec), .rirr_set(rirr_set),
        .rirr_status(rirr_status)
    );

    // reference model built from the requirements
    logic [31:0] m_lo [N];
    logic [31:0] m_hi [N];
    logic [31:0] m_id;
    logic [31:0] m_bcfg;
    logic [N-1:0] m_rirr;
    logic [7:0]  m_idx;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  reported = 0;

    function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] n,
                                        input logic [31:0] m);
        return (o & ~m) | (n & m);
    endfunction

    function automatic bit is_tbl(input logic [7:0] k);
        return int'(k) >= BASE && int'(k) < TEND;
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] k);
        int e;
        if (k == 8'h00) return m_id;
        if (k == 8'h01) return {8'h00, 8'(N - 1), 8'h80, 8'h20};
        if (k == 8'h03) return m_bcfg;
        if (is_tbl(k)) begin
            e = (int'(k) - BASE) / 2;
            if (((int'(k) - BASE) % 2) == 0) return m_lo[e] | (32'(m_rirr[e]) << 14);
            return m_hi[e];
        end
        return 32'h0;
    endfunction

    function automatic string wr_tag(input logic [7:0] k);
        if (k == 8'h00 || k == 8'h03 || is_tbl(k)) return "R4";
        return "R5";
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_lo[i] = 32'h0001_0000;
            m_hi[i] = 32'h0;
        end
        m_id = 32'h0; m_bcfg = 32'h1; m_rirr = '0; m_idx = 8'h00;
    endtask

    task automatic model_write(input logic [7:0] k, input logic [31:0] d);
        int e;
        if (k == 8'h00) m_id = mrg(m_id, d, 32'h0F00_0000);
        else if (k == 8'h03) m_bcfg = mrg(m_bcfg, d, 32'h1);
        else if (is_tbl(k)) begin
            e = (int'(k) - BASE) / 2;
            if (((int'(k) - BASE) % 2) == 0) m_lo[e] = mrg(m_lo[e], d, 32'h0001_BFFF);
            else m_hi[e] = mrg(m_hi[e], d, 32'hFF00_0000);
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive one cycle of stimulus at a falling edge, update model at the rising edge,
    // then check read data and status at the next falling edge
    task automatic step(input string tag, input bit iw, input logic [7:0] iv,
                        input bit ww, input logic [31:0] wv,
                        input bit ew, input logic [7:0] ev, input logic [N-1:0] sp);
        logic [N-1:0] nr;
        idx_we = iw; idx_wdata = iv; win_we = ww; win_wdata = wv;
        eoi_we = ew; eoi_vec = ev; rirr_set = sp;
        @(posedge clk);
        nr = m_rirr;
        for (int i = 0; i < N; i++) begin
            if (sp[i]) nr[i] = 1'b1;
            else if (ew && m_lo[i][7:0] == ev) nr[i] = 1'b0;
        end
        if (ww) model_write(m_idx, wv);
        if (iw) m_idx = iv;
        m_rirr = nr;
        @(negedge clk);
        idx_we = 1'b0; win_we = 1'b0; eoi_we = 1'b0; rirr_set = '0;
        chk(tag, win_rdata, exp_read(m_idx));
        chk(tag, 32'(rirr_status), 32'(m_rirr));
    endtask

    task automatic sel_idx(input string tag, input logic [7:0] k);
        step(tag, 1'b1, k, 1'b0, 32'h0, 1'b0, 8'h0, '0);
    endtask

    task automatic wr_reg(input string tag, input logic [7:0] k, input logic [31:0] d);
        sel_idx(tag, k);
        step(tag, 1'b0, 8'h0, 1'b1, d, 1'b0, 8'h0, '0);
    endtask

    task automatic finish_report();
        if (!reported) begin
            reported = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        end
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_report();
    end

    initial begin
        logic [N-1:0] sp;
        logic [31:0]  d;
        logic [7:0]   k;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values across the whole index space
        chk("R1", 32'(rirr_status), 32'h0);
        chk("R1", win_rdata, 32'h0);
        for (int i = 0; i < 256; i++) sel_idx((i == 1 || !is_tbl(8'(i)) && i != 0 && i != 3) ? "R5" : "R1", 8'(i));
        sel_idx("R1", 8'h10);
        chk("R1", win_rdata, 32'h0001_0000);
        sel_idx("R3", 8'h3F);
        chk("R3", win_rdata, 32'h0);
        sel_idx("R5", 8'h40);
        chk("R5", win_rdata, 32'h0);

        // R4 / R5 / R6: write all ones everywhere
        for (int i = 0; i < 256; i++) wr_reg(wr_tag(8'(i)), 8'(i), 32'hFFFF_FFFF);
        sel_idx("R5", 8'h01);
        chk("R5", win_rdata, 32'h0017_8020);
        sel_idx("R6", 8'h1A);
        chk("R6", {31'b0, win_rdata[14]}, 32'h0);
        sel_idx("R4", 8'h00);
        chk("R4", win_rdata, 32'h0F00_0000);

        // R7 / R8: shared vectors 55h on entries 3 and 7, 66h on entry 20
        wr_reg("R3", 8'h16, 32'h0000_0055);
        wr_reg("R3", 8'h1E, 32'h0000_0055);
        wr_reg("R3", 8'h38, 32'h0000_0066);
        sp = '0; sp[3] = 1'b1; sp[7] = 1'b1; sp[20] = 1'b1;
        step("R7", 1'b1, 8'h16, 1'b0, 32'h0, 1'b0, 8'h0, sp);
        chk("R7", 32'(rirr_status), 32'h0010_0088);
        chk("R6", {31'b0, win_rdata[14]}, 32'h1);
        step("R8", 1'b0, 8'h0, 1'b0, 32'h0, 1'b1, 8'h55, '0);
        chk("R8", 32'(rirr_status), 32'h0010_0000);
        chk("R6", {31'b0, win_rdata[14]}, 32'h0);

        // R9: set wins over a matching clear in the same cycle
        sp = '0; sp[20] = 1'b1;
        step("R9", 1'b0, 8'h0, 1'b0, 32'h0, 1'b1, 8'h66, sp);
        chk("R9", 32'(rirr_status[20]), 32'h1);
        step("R8", 1'b0, 8'h0, 1'b0, 32'h0, 1'b1, 8'h66, '0);
        chk("R8", 32'(rirr_status[20]), 32'h0);

        // R10: same-cycle index and window write goes to the old index
        sel_idx("R10", 8'h00);
        step("R10", 1'b1, 8'h03, 1'b1, 32'h0000_0000, 1'b0, 8'h0, '0);
        sel_idx("R10", 8'h00);
        chk("R10", win_rdata, 32'h0);
        sel_idx("R10", 8'h03);
        chk("R10", win_rdata, 32'h1);
        // R10: EOI compares against vector before a same-cycle rewrite
        sp = '0; sp[7] = 1'b1;
        step("R7", 1'b1, 8'h1E, 1'b0, 32'h0, 1'b0, 8'h0, sp);
        step("R10", 1'b0, 8'h0, 1'b1, 32'h0000_0077, 1'b1, 8'h55, '0);
        chk("R10", 32'(rirr_status[7]), 32'h0);
        step("R7", 1'b0, 8'h0, 1'b0, 32'h0, 1'b0, 8'h0, sp);
        step("R8", 1'b0, 8'h0, 1'b0, 32'h0, 1'b1, 8'h55, '0);
        chk("R8", 32'(rirr_status[7]), 32'h1);

        // constrained random mix
        for (int n = 0; n < 4000; n++) begin
            k = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 72);
            d = $urandom;
            if ($urandom % 2 == 0) d[7:0] = 8'h30 + 8'($urandom % 4);
            sp = '0;
            for (int i = 0; i < N; i++) if ($urandom % 16 == 0) sp[i] = 1'b1;
            step("R2", ($urandom % 3) == 0, k, ($urandom % 3) == 0, d,
                 ($urandom % 4) == 0, 8'h30 + 8'($urandom % 4), sp);
        end

        finish_report();
    end

endmodule